// File: doc/BRIEF.md
# Fragment Reassembling Slot Receiver

This block drains 32-bit slots from a queue that a coprocessor fills toward the host. It rebuilds one message from one or more fragments and writes the payload bytes to a local byte-wide buffer at consecutive addresses. Each fragment begins with a header slot. The header holds the payload length in bytes and a flag that marks the last fragment. The payload slots follow the header. After the payload words, the receiver checks that the peer is still ready. If a fragment is not the last one and the queue has run empty, the receiver pulses a doorbell to ask the peer for more data.

The host starts an operation with a start pulse and gives the buffer capacity in bytes. The operation ends with a one-cycle done pulse. If the operation failed, the error output is high in that same cycle. After a successful operation, the total byte count stays on the received-length output. Every wait for a queue slot is limited by a cycle timeout that software programs.

Top module: `frag_rx`

## Requirements
- R1: A start pulse with `capBytes` equal to 0 ends the operation with `done` and `error` high in the next cycle. Nothing is popped and nothing is written.
- R2: The receiver waits until `fillCount` is nonzero and then pops one header slot. The fragment length is taken from `slotData[24:16]` and the last-fragment flag from bit 31. All other header bits are ignored.
- R3: If a fragment's length is greater than the capacity still unused, the operation ends with an error. No byte of that fragment is written.
- R4: The payload of a fragment occupies ceil(length/4) slots. Each slot is unpacked little-endian: bits 7:0 go to the lowest address. Addresses start at 0 for each operation and continue across fragments without gaps.
- R5: In a trailing partial slot, only the low (length mod 4) bytes are written.
- R6: `peerReady` is sampled after the fragment's whole payload words have been read and before its partial slot, if it has one. If it is low, the operation ends with an error.
- R7: When a fragment without the last-fragment flag finishes while `fillCount` is 0, `doorbell` pulses for one cycle. If slots are still queued, there is no pulse.
- R8: A fragment with the last-fragment flag ends the operation with `error` low. `rxLen` then equals the total number of bytes written.
- R9: A zero-length fragment is accepted. It sets `zeroWarn`, which stays high until the next start.
- R10: While the receiver waits for a slot, if the queue stays empty for `timeoutLimit`+1 consecutive cycles, the operation ends with an error.
- R11: `slotPop` is high only in a cycle where `fillCount` is nonzero. The popped word is the `slotData` of that same cycle.
- R12: After reset, `done`, `error`, `slotPop`, `wrEn` and `doorbell` are low and `rxLen` is 0. `done` lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins an operation when the block is idle |
| capBytes | input | CAP_W | Buffer capacity in bytes, sampled at start |
| timeoutLimit | input | TO_W | Maximum wait for a slot, in cycles minus one |
| fillCount | input | FILL_W | Number of filled slots in the queue |
| peerReady | input | 1 | High while the peer is ready |
| slotData | input | 32 | Word at the head of the queue |
| slotPop | output | 1 | Removes the head slot |
| wrEn | output | 1 | Byte write strobe |
| wrAddr | output | CAP_W | Byte write address |
| wrData | output | 8 | Byte write data |
| doorbell | output | 1 | Requests more data from the peer |
| rxLen | output | CAP_W | Number of bytes written in this operation |
| zeroWarn | output | 1 | A zero-length fragment was received |
| done | output | 1 | The operation has ended (one-cycle pulse) |
| error | output | 1 | The operation failed, valid with done |

## Verification
The bench runs lengths that end exactly on a slot boundary and lengths that leave one to three trailing bytes. A design that wrote whole partial slots would overwrite buffer bytes beyond the message. A design that dropped the tail would report too few bytes. Capacity is exercised at its exact limit, one byte below it, and in a case where it runs out only in the second fragment. A design that compared the length against the full capacity, instead of the capacity still unused, would write past the buffer. The doorbell is tested both with the queue drained between fragments and with the queue still filled. A receiver that rang the doorbell without checking the queue, or that stalled without ringing it, fails these cases. The bench also counts the exact cycle in which the empty-queue timeout expires, so an off-by-one in the timer shows up.

// File: rtl/frag_rx_pkg.sv
package frag_rx_pkg;
  localparam int LEN_W      = 9;
  localparam int LEN_LSB    = 16;
  localparam int LAST_BIT   = 31;
  localparam int SLOT_W     = 32;
  localparam int WHOLE_W    = LEN_W - 2;

  typedef enum logic [2:0] {
    S_IDLE,
    S_HDR,
    S_WAITW,
    S_UNPACK,
    S_CHK,
    S_NEXT,
    S_DONE
  } rxState_t;

  typedef struct packed {
    logic init;
    logic hdrLoad;
    logic wordLoad;
    logic byteWr;
    logic wholeDec;
    logic timerInc;
    logic timerClr;
  } rxStrobe_t;
endpackage

// File: rtl/frag_rx_dp.sv
module frag_rx_dp
  import frag_rx_pkg::*;
#(
  parameter int CAP_W  = 12,
  parameter int FILL_W = 8,
  parameter int TO_W   = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  rxStrobe_t          st,
  input  logic [CAP_W-1:0]   capBytes,
  input  logic [TO_W-1:0]    timeoutLimit,
  input  logic [FILL_W-1:0]  fillCount,
  input  logic [SLOT_W-1:0]  slotData,
  output logic               capZero,
  output logic               slotAvail,
  output logic               timeoutHit,
  output logic               lenTooBig,
  output logic               hdrWholeZero,
  output logic               wholeIsOne,
  output logic               tailNonZero,
  output logic               lastFull,
  output logic               lastTail,
  output logic               fragLast,
  output logic [CAP_W-1:0]   wrAddr,
  output logic [7:0]         wrData,
  output logic [CAP_W-1:0]   rxLen,
  output logic               zeroWarn
);
  localparam int CMP_W = (CAP_W > LEN_W) ? CAP_W : LEN_W;

  logic [CAP_W-1:0]   capReg;
  logic [CAP_W-1:0]   addrCnt;
  logic [LEN_W-1:0]   hdrLen;
  logic               hdrLast;
  logic [WHOLE_W-1:0] wholeLeft;
  logic [SLOT_W-1:0]  wordReg;
  logic [1:0]         byteIdx;
  logic [TO_W-1:0]    timer;
  logic               warnReg;

  logic [LEN_W-1:0]   slotLen;
  logic [CAP_W-1:0]   room;

  assign slotLen      = slotData[LEN_LSB +: LEN_W];
  assign room         = capReg - addrCnt;
  assign lenTooBig    = CMP_W'(slotLen) > CMP_W'(room);
  assign hdrWholeZero = (slotLen[LEN_W-1:2] == '0);
  assign capZero      = (capBytes == '0);
  assign slotAvail    = (fillCount != '0);
  assign timeoutHit   = (timer == timeoutLimit);
  assign wholeIsOne   = (wholeLeft == WHOLE_W'(1));
  assign tailNonZero  = (hdrLen[1:0] != 2'd0);
  assign lastFull     = (byteIdx == 2'd3);
  assign lastTail     = (byteIdx == (hdrLen[1:0] - 2'd1));
  assign fragLast     = hdrLast;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capReg    <= '0;
      addrCnt   <= '0;
      hdrLen    <= '0;
      hdrLast   <= 1'b0;
      wholeLeft <= '0;
      wordReg   <= '0;
      byteIdx   <= '0;
      timer     <= '0;
      warnReg   <= 1'b0;
    end else begin
      if (st.init) begin
        capReg  <= capBytes;
        addrCnt <= '0;
        warnReg <= 1'b0;
      end
      if (st.timerClr || st.init) begin
        timer <= '0;
      end else if (st.timerInc) begin
        timer <= timer + TO_W'(1);
      end
      if (st.hdrLoad) begin
        hdrLen    <= slotLen;
        hdrLast   <= slotData[LAST_BIT];
        wholeLeft <= slotLen[LEN_W-1:2];
        if (slotLen == '0) warnReg <= 1'b1;
      end
      if (st.wordLoad) begin
        wordReg <= slotData;
        byteIdx <= '0;
      end
      if (st.byteWr) begin
        addrCnt <= addrCnt + CAP_W'(1);
        byteIdx <= byteIdx + 2'd1;
      end
      if (st.wholeDec) begin
        wholeLeft <= wholeLeft - WHOLE_W'(1);
      end
    end
  end

  assign wrAddr   = addrCnt;
  assign wrData   = wordReg[{byteIdx, 3'b000} +: 8];
  assign rxLen    = addrCnt;
  assign zeroWarn = warnReg;
endmodule

// File: rtl/frag_rx_ctrl.sv
module frag_rx_ctrl
  import frag_rx_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  logic      peerReady,
  input  logic      capZero,
  input  logic      slotAvail,
  input  logic      timeoutHit,
  input  logic      lenTooBig,
  input  logic      hdrWholeZero,
  input  logic      wholeIsOne,
  input  logic      tailNonZero,
  input  logic      lastFull,
  input  logic      lastTail,
  input  logic      fragLast,
  output rxStrobe_t st,
  output logic      slotPop,
  output logic      doorbell,
  output logic      done,
  output logic      error
);
  rxState_t state, stateNext;
  logic     isTail, isTailNext;
  logic     errFlag, errNext;

  always_comb begin
    st         = '0;
    stateNext  = state;
    isTailNext = isTail;
    errNext    = errFlag;
    slotPop    = 1'b0;
    doorbell   = 1'b0;
    unique case (state)
      S_IDLE: begin
        if (start) begin
          st.init = 1'b1;
          if (capZero) begin
            errNext   = 1'b1;
            stateNext = S_DONE;
          end else begin
            errNext   = 1'b0;
            stateNext = S_HDR;
          end
        end
      end
      S_HDR: begin
        if (slotAvail) begin
          slotPop     = 1'b1;
          st.hdrLoad  = 1'b1;
          st.timerClr = 1'b1;
          isTailNext  = 1'b0;
          if (lenTooBig) begin
            errNext   = 1'b1;
            stateNext = S_DONE;
          end else if (hdrWholeZero) begin
            stateNext = S_CHK;
          end else begin
            stateNext = S_WAITW;
          end
        end else if (timeoutHit) begin
          errNext   = 1'b1;
          stateNext = S_DONE;
        end else begin
          st.timerInc = 1'b1;
        end
      end
      S_WAITW: begin
        if (slotAvail) begin
          slotPop     = 1'b1;
          st.wordLoad = 1'b1;
          st.timerClr = 1'b1;
          stateNext   = S_UNPACK;
        end else if (timeoutHit) begin
          errNext   = 1'b1;
          stateNext = S_DONE;
        end else begin
          st.timerInc = 1'b1;
        end
      end
      S_UNPACK: begin
        st.byteWr = 1'b1;
        if (isTail) begin
          if (lastTail) stateNext = S_NEXT;
        end else if (lastFull) begin
          st.wholeDec = 1'b1;
          stateNext   = wholeIsOne ? S_CHK : S_WAITW;
        end
      end
      S_CHK: begin
        if (!peerReady) begin
          errNext   = 1'b1;
          stateNext = S_DONE;
        end else if (tailNonZero) begin
          isTailNext = 1'b1;
          stateNext  = S_WAITW;
        end else begin
          stateNext = S_NEXT;
        end
      end
      S_NEXT: begin
        if (fragLast) begin
          errNext   = 1'b0;
          stateNext = S_DONE;
        end else begin
          doorbell  = !slotAvail;
          stateNext = S_HDR;
        end
      end
      S_DONE: stateNext = S_IDLE;
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      isTail  <= 1'b0;
      errFlag <= 1'b0;
    end else begin
      state   <= stateNext;
      isTail  <= isTailNext;
      errFlag <= errNext;
    end
  end

  assign done  = (state == S_DONE);
  assign error = (state == S_DONE) && errFlag;
endmodule

// File: rtl/frag_rx.sv
module frag_rx
  import frag_rx_pkg::*;
#(
  parameter int CAP_W  = 12,
  parameter int FILL_W = 8,
  parameter int TO_W   = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [CAP_W-1:0]  capBytes,
  input  logic [TO_W-1:0]   timeoutLimit,
  input  logic [FILL_W-1:0] fillCount,
  input  logic              peerReady,
  input  logic [31:0]       slotData,
  output logic              slotPop,
  output logic              wrEn,
  output logic [CAP_W-1:0]  wrAddr,
  output logic [7:0]        wrData,
  output logic              doorbell,
  output logic [CAP_W-1:0]  rxLen,
  output logic              zeroWarn,
  output logic              done,
  output logic              error
);
  rxStrobe_t st;
  logic capZero, slotAvail, timeoutHit, lenTooBig, hdrWholeZero;
  logic wholeIsOne, tailNonZero, lastFull, lastTail, fragLast;

  frag_rx_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .peerReady(peerReady),
    .capZero(capZero), .slotAvail(slotAvail), .timeoutHit(timeoutHit),
    .lenTooBig(lenTooBig), .hdrWholeZero(hdrWholeZero),
    .wholeIsOne(wholeIsOne), .tailNonZero(tailNonZero),
    .lastFull(lastFull), .lastTail(lastTail), .fragLast(fragLast),
    .st(st), .slotPop(slotPop), .doorbell(doorbell),
    .done(done), .error(error)
  );

  frag_rx_dp #(.CAP_W(CAP_W), .FILL_W(FILL_W), .TO_W(TO_W)) i_dp (
    .clk(clk), .rstN(rstN), .st(st), .capBytes(capBytes),
    .timeoutLimit(timeoutLimit), .fillCount(fillCount), .slotData(slotData),
    .capZero(capZero), .slotAvail(slotAvail), .timeoutHit(timeoutHit),
    .lenTooBig(lenTooBig), .hdrWholeZero(hdrWholeZero),
    .wholeIsOne(wholeIsOne), .tailNonZero(tailNonZero),
    .lastFull(lastFull), .lastTail(lastTail), .fragLast(fragLast),
    .wrAddr(wrAddr), .wrData(wrData), .rxLen(rxLen), .zeroWarn(zeroWarn)
  );

  assign wrEn = st.byteWr;
endmodule

// File: rtl/frag_rx_chk.sv
module frag_rx_chk #(
  parameter int CAP_W  = 12,
  parameter int FILL_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic [CAP_W-1:0]  capBytes,
  input logic [FILL_W-1:0] fillCount,
  input logic              slotPop,
  input logic              wrEn,
  input logic [CAP_W-1:0]  wrAddr,
  input logic              doorbell,
  input logic              done,
  input logic              error
);
  logic             running;
  logic [CAP_W-1:0] capSeen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running <= 1'b0;
      capSeen <= '0;
    end else if (done) begin
      running <= 1'b0;
    end else if (start && !running) begin
      running <= 1'b1;
      capSeen <= capBytes;
    end
  end

  p_pop_has_slot_r11: assert property (@(posedge clk) disable iff (!rstN)
    slotPop |-> fillCount != '0);

  p_write_in_range_r3: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> wrAddr < capSeen);

  p_addr_step_r4: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && $past(wrEn)) |-> wrAddr == $past(wrAddr) + CAP_W'(1));

  p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_bell_empty_r7: assert property (@(posedge clk) disable iff (!rstN)
    doorbell |-> (fillCount == '0) && !done);

  p_error_with_done_r8: assert property (@(posedge clk) disable iff (!rstN)
    error |-> done);

  p_cap_zero_r1: assert property (@(posedge clk) disable iff (!rstN)
    (start && !running && capBytes == '0) |=> (done && error));
endmodule

bind frag_rx frag_rx_chk #(.CAP_W(CAP_W), .FILL_W(FILL_W)) i_frag_rx_chk (
  .clk(clk), .rstN(rstN), .start(start), .capBytes(capBytes),
  .fillCount(fillCount), .slotPop(slotPop), .wrEn(wrEn), .wrAddr(wrAddr),
  .doorbell(doorbell), .done(done), .error(error)
);

// File: tb/test_frag_rx.sv
module test_frag_rx;
  localparam int CAP_W = 12;
  localparam int FILL_W = 8;
  localparam int TO_W = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [CAP_W-1:0] capBytes = '0;
  logic [TO_W-1:0] timeoutLimit = 16'd1000;
  logic [FILL_W-1:0] fillCount;
  logic peerReady = 1'b1;
  logic [31:0] slotData;
  logic slotPop, wrEn, doorbell, zeroWarn, done, error;
  logic [CAP_W-1:0] wrAddr, rxLen;
  logic [7:0] wrData;

  always #4 clk = ~clk;

  frag_rx #(.CAP_W(CAP_W), .FILL_W(FILL_W), .TO_W(TO_W)) i_frag_rx (
    .clk(clk), .rstN(rstN), .start(start), .capBytes(capBytes),
    .timeoutLimit(timeoutLimit), .fillCount(fillCount), .peerReady(peerReady),
    .slotData(slotData), .slotPop(slotPop), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .doorbell(doorbell), .rxLen(rxLen), .zeroWarn(zeroWarn),
    .done(done), .error(error)
  );

  // queue model
  logic [31:0] qMem [0:63];
  int qHead = 0;
  int qTail = 0;
  logic flushReq = 1'b0;
  assign fillCount = FILL_W'(qTail - qHead);
  assign slotData  = qMem[qHead % 64];
  always @(posedge clk) begin
    if (flushReq) qHead <= qTail;
    else if (slotPop) qHead <= qHead + 1;
  end

  // buffer and event capture
  logic [7:0] bmem [0:4095];
  int wrTotal = 0, bellTotal = 0, doneTotal = 0, cyc = 0;
  logic lastErr = 1'b0;
  logic [CAP_W-1:0] lastLen = '0;
  always @(posedge clk) begin
    if (wrEn) begin
      bmem[wrAddr] <= wrData;
      wrTotal <= wrTotal + 1;
    end
    if (doorbell) bellTotal <= bellTotal + 1;
    if (done) begin
      doneTotal <= doneTotal + 1;
      lastErr <= error;
      lastLen <= rxLen;
    end
  end

  int total = 0, bad = 0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      bad = bad + 1;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int b);
    return 8'((b * 7 + 13) & 255);
  endfunction

  task automatic push(input logic [31:0] w);
    qMem[qTail % 64] = w;
    qTail = qTail + 1;
  endtask

  task automatic pushFrag(input int len, input bit last, input int off, input logic [31:0] junk);
    push((32'(last) << 31) | (32'(len) << 16) | junk);
    for (int s = 0; s < (len + 3) / 4; s++) begin
      push({pat(off + 4*s + 3), pat(off + 4*s + 2), pat(off + 4*s + 1), pat(off + 4*s)});
    end
  endtask

  task automatic flush();
    @(negedge clk) flushReq = 1'b1;
    @(negedge clk) flushReq = 1'b0;
  endtask

  task automatic pulseStart(input int cap);
    capBytes = CAP_W'(cap);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic waitDone(input int base, output bit ok);
    int n = 0;
    while (doneTotal == base && n < 5000) begin
      @(negedge clk);
      n++;
    end
    ok = (doneTotal != base);
    @(negedge clk);
  endtask

  task automatic checkBytes(input int n, input string tag);
    int mism = 0;
    for (int k = 0; k < n; k++) if (bmem[k] !== pat(k)) mism++;
    chk(mism == 0, tag, mism, 0);
  endtask

  // {len[8:0], cap[11:0], expErr}
  localparam logic [21:0] VECS [8] = '{
    {9'd5,  12'd100, 1'b0},
    {9'd8,  12'd8,   1'b0},
    {9'd3,  12'd16,  1'b0},
    {9'd4,  12'd3,   1'b1},
    {9'd1,  12'd1,   1'b0},
    {9'd0,  12'd4,   1'b0},
    {9'd9,  12'd8,   1'b1},
    {9'd12, 12'd40,  1'b0}
  };

  initial begin
    bit ok;
    int bw, bd, bb;
    for (int k = 0; k < 4096; k++) bmem[k] = 8'hxx;
    repeat (3) @(negedge clk);
    // R12 reset state
    chk(!done && !error && !slotPop && !wrEn && !doorbell, "R12 reset outputs",
        int'({done, error, slotPop, wrEn, doorbell}), 0);
    chk(rxLen == 0, "R12 reset rxLen", int'(rxLen), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // table walk: single fragments (R2 R3 R4 R5 R8 R9)
    for (int i = 0; i < 8; i++) begin
      int len = int'(VECS[i][21:13]);
      int cap = int'(VECS[i][12:1]);
      bit expErr = VECS[i][0];
      bw = wrTotal; bd = doneTotal;
      pushFrag(len, 1'b1, 0, 32'h0000_0201);
      pulseStart(cap);
      waitDone(bd, ok);
      chk(ok, "R8 table done seen", int'(ok), 1);
      chk(lastErr == expErr, "R3 table error flag", int'(lastErr), int'(expErr));
      chk(wrTotal - bw == (expErr ? 0 : len), "R5 table bytes written", wrTotal - bw, expErr ? 0 : len);
      if (!expErr) begin
        chk(int'(lastLen) == len, "R8 table rxLen", int'(lastLen), len);
        checkBytes(len, "R4 table byte order");
      end
      chk(zeroWarn == (len == 0), "R9 zero warn", int'(zeroWarn), int'(len == 0));
      flush();
    end

    // R1 zero capacity
    bw = wrTotal; bd = doneTotal;
    pushFrag(4, 1'b1, 0, 0);
    pulseStart(0);
    waitDone(bd, ok);
    chk(ok && lastErr, "R1 zero capacity error", int'(lastErr), 1);
    chk(fillCount == 2 && wrTotal == bw, "R1 nothing popped", int'(fillCount), 2);
    flush();

    // R7 R2 two fragments queued upfront, junk header bits, no doorbell
    bw = wrTotal; bd = doneTotal; bb = bellTotal;
    pushFrag(6, 1'b0, 0, 32'h7E00_ABCD);
    pushFrag(5, 1'b1, 6, 32'h7E00_1234);
    pulseStart(64);
    waitDone(bd, ok);
    chk(ok && !lastErr && lastLen == 11, "R2 two frag rxLen", int'(lastLen), 11);
    chk(bellTotal == bb, "R7 no doorbell when filled", bellTotal - bb, 0);
    checkBytes(11, "R4 two frag bytes");
    flush();

    // R7 doorbell when queue empties mid-message
    bd = doneTotal; bb = bellTotal;
    pushFrag(6, 1'b0, 0, 0);
    pulseStart(64);
    begin
      int n = 0;
      while (bellTotal == bb && n < 2000) begin @(negedge clk); n++; end
    end
    chk(bellTotal - bb == 1, "R7 doorbell pulse", bellTotal - bb, 1);
    pushFrag(7, 1'b1, 6, 0);
    waitDone(bd, ok);
    chk(ok && !lastErr && lastLen == 13, "R8 after doorbell rxLen", int'(lastLen), 13);
    checkBytes(13, "R4 after doorbell bytes");
    flush();

    // R3 capacity runs out in second fragment
    bw = wrTotal; bd = doneTotal;
    pushFrag(6, 1'b0, 0, 0);
    pushFrag(5, 1'b1, 6, 0);
    pulseStart(10);
    waitDone(bd, ok);
    chk(ok && lastErr, "R3 second frag overflow error", int'(lastErr), 1);
    chk(wrTotal - bw == 6, "R3 second frag not written", wrTotal - bw, 6);
    flush();

    // R6 peer not ready after whole words
    bw = wrTotal; bd = doneTotal;
    peerReady = 1'b0;
    pushFrag(6, 1'b1, 0, 0);
    pulseStart(64);
    waitDone(bd, ok);
    chk(ok && lastErr, "R6 peer not ready error", int'(lastErr), 1);
    chk(wrTotal - bw == 4, "R6 tail slot not taken", wrTotal - bw, 4);
    peerReady = 1'b1;
    flush();

    // R10 timeout on empty queue
    timeoutLimit = 16'd20;
    bd = doneTotal;
    begin
      int n = 0;
      capBytes = 12'd64;
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
      n = 1;
      while (!done && n < 200) begin @(negedge clk); n++; end
      chk(done && error, "R10 timeout error", int'(error), 1);
      chk(n == 22, "R10 timeout cycle", n, 22);
    end
    @(negedge clk);
    timeoutLimit = 16'd1000;

    // R12 done is a pulse
    chk(!done, "R12 done single cycle", int'(done), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule